// File: doc/BRIEF.md
# Predictive Dead-Time Gate Controller

This block turns a raw pulse-width-modulated command into two complementary gate commands for the upper and lower switches of a synchronous buck stage. It inserts a dead time at every transition so that the two switches are never on together. The length of each dead time is learned from one cycle to the next. While a gap is open, a comparator flag reports whether the switching node swung below ground, which shows that the lower switch's body diode was conducting. If it did, the gap that just ran was longer than it needed to be, so that gap is trimmed by one clock for the next cycle. If it did not, the gap is widened by one clock. Each gap therefore settles on the shortest setting that is still safe.

The rising-edge gap (lower switch off, then upper switch on) and the falling-edge gap (upper switch off, then lower switch on) each have their own register. When the stage sinks current, the switching node never goes negative, so the flag carries no information. A sinking indication captured at the start of a gap makes that gap use a fixed fallback length and leaves both learned values untouched. One step is one clock period, so at 200 MHz the default start value of 4 steps is 20 ns.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: `hiGate` and `loGate` are never both 1 in the same cycle.
- R2: While reset is held, both gates are 0 and both delay outputs equal `DT_INIT` (4). At the first clock edge after reset is released, the gate that matches `pwmIn` turns on at once, and no delay value changes.
- R3: When `pwmIn` = 1 is sampled with the lower gate on, `loGate` drops after that edge. Both gates then stay off for exactly D cycles, and `hiGate` rises after the D-th following edge. D is the value `riseDelay` had when the gap opened.
- R4: When `pwmIn` = 0 is sampled with the upper gate on, `hiGate` drops after that edge. Both gates then stay off for exactly D cycles, and `loGate` rises after the D-th following edge. D is the value `fallDelay` had when the gap opened.
- R5: If `phaseNeg` is 1 at any clock edge inside a completed gap, and the gap is not in fallback mode, then that gap's delay register drops by 1 when the gate turns on. It does not drop below `DT_MIN` (1).
- R6: If `phaseNeg` is 0 at every clock edge inside a completed gap, and the gap is not in fallback mode, then that gap's delay register rises by 1 when the gate turns on. It does not rise above `DT_MAX` (20).
- R7: A rising-edge gap changes only `riseDelay`, and a falling-edge gap changes only `fallDelay`.
- R8: If `sinkMode` is 1 at the edge where a gap opens, that gap lasts exactly `ADAPT_DLY` (6) cycles whatever its learned value is, and neither delay register changes.
- R9: If `pwmIn` goes back to its previous level while a gap is open, the gate that was just switched off turns back on after the next edge. This takes priority over finishing the gap, and the delay registers do not change.
- R10: `riseDelay` and `fallDelay` always lie within `DT_MIN`..`DT_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one dead-time step per period |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmIn | input | 1 | Raw PWM command, 1 = upper switch wanted |
| phaseNeg | input | 1 | Comparator flag: switching node below the negative threshold |
| sinkMode | input | 1 | Stage is sinking current; selects the fixed fallback gap |
| hiGate | output | 1 | Upper switch gate command |
| loGate | output | 1 | Lower switch gate command |
| riseDelay | output | DLY_W (5) | Learned rising-edge gap in clock cycles |
| fallDelay | output | DLY_W (5) | Learned falling-edge gap in clock cycles |

## Verification
The bench drives both learned values into `DT_MAX` and `DT_MIN` and past them. A design with a missing or off-by-one clamp would wrap around or stop one step short of the limit. Every gap is timed cycle by cycle from the value it opened with, so a counter that starts at the wrong count gives a gap one cycle too long or too short. A design that updates from the new value rather than the old one would also be caught, as would one that lets a rising-edge update change the falling register. Glitches on `pwmIn` shorter than a gap are checked to restore the previous gate with both values unchanged. Windows flagged as sinking are checked to use the fallback length and to freeze learning, which a design that ignored the sinking indication would fail.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

  typedef enum logic [2:0] {
    ST_SAFE,
    ST_LOW,
    ST_RISE_GAP,
    ST_HIGH,
    ST_FALL_GAP
  } gate_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;      // a gap opens this edge
    logic startRise;  // the opening gap is the rising-edge one
    logic tick;       // gap continues: count and sample the comparator
    logic commit;     // gap completes: update the learned value
  } gap_strobe_t;

endpackage

// File: rtl/dtg_trim.sv
`timescale 1ns/1ps
module dtg_trim #(
  parameter int DT_MIN  = 1,
  parameter int DT_MAX  = 20,
  parameter int DT_INIT = 4,
  localparam int DLY_W  = $clog2(DT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             shorten,
  output logic [DLY_W-1:0] value
);

  localparam logic [DLY_W-1:0] MIN_V  = DLY_W'(DT_MIN);
  localparam logic [DLY_W-1:0] MAX_V  = DLY_W'(DT_MAX);
  localparam logic [DLY_W-1:0] INIT_V = DLY_W'(DT_INIT);

  logic [DLY_W-1:0] nextVal;

  always_comb begin
    if (shorten) begin
      nextVal = (value > MIN_V) ? value - 1'b1 : MIN_V;
    end else begin
      nextVal = (value < MAX_V) ? value + 1'b1 : MAX_V;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= INIT_V;
    end else if (load) begin
      value <= nextVal;
    end
  end

endmodule

// File: rtl/dtg_datapath.sv
`timescale 1ns/1ps
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int DT_MIN    = 1,
  parameter int DT_MAX    = 20,
  parameter int DT_INIT   = 4,
  parameter int ADAPT_DLY = 6,
  localparam int DLY_W    = $clog2(DT_MAX + 1),
  localparam int LIM_MAX  = (DT_MAX > ADAPT_DLY) ? DT_MAX : ADAPT_DLY,
  localparam int CNT_W    = $clog2(LIM_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseNeg,
  input  logic             sinkMode,
  input  gap_strobe_t      strobe,
  output logic             gapDone,
  output logic [DLY_W-1:0] riseDelay,
  output logic [DLY_W-1:0] fallDelay
);

  logic [CNT_W-1:0] gapCnt;
  logic [CNT_W-1:0] gapLimit;
  logic             gapIsRise;
  logic             adaptWin;
  logic             sawNeg;
  logic             shortenNow;
  logic [DLY_W-1:0] trimVal [2];

  // index 0 tracks the falling-edge gap, index 1 the rising-edge gap
  generate
    for (genvar e = 0; e < 2; e++) begin : g_edge
      logic loadThis;
      assign loadThis = strobe.commit && !adaptWin && (gapIsRise == 1'(e));
      dtg_trim #(
        .DT_MIN (DT_MIN),
        .DT_MAX (DT_MAX),
        .DT_INIT(DT_INIT)
      ) trimInst (
        .clk    (clk),
        .rstN   (rstN),
        .load   (loadThis),
        .shorten(shortenNow),
        .value  (trimVal[e])
      );
    end
  endgenerate

  assign riseDelay  = trimVal[1];
  assign fallDelay  = trimVal[0];
  assign shortenNow = sawNeg | phaseNeg;

  always_comb begin
    if (adaptWin) begin
      gapLimit = CNT_W'(ADAPT_DLY);
    end else if (gapIsRise) begin
      gapLimit = CNT_W'(riseDelay);
    end else begin
      gapLimit = CNT_W'(fallDelay);
    end
  end

  assign gapDone = (gapCnt >= gapLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= '0;
      gapIsRise <= 1'b0;
      adaptWin  <= 1'b0;
      sawNeg    <= 1'b0;
    end else if (strobe.start) begin
      gapCnt    <= CNT_W'(1);
      gapIsRise <= strobe.startRise;
      adaptWin  <= sinkMode;
      sawNeg    <= 1'b0;
    end else if (strobe.tick) begin
      gapCnt    <= gapCnt + 1'b1;
      sawNeg    <= sawNeg | phaseNeg;
    end
  end

endmodule

// File: rtl/dtg_control.sv
`timescale 1ns/1ps
module dtg_control
  import dtg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwmIn,
  input  logic        gapDone,
  output gap_strobe_t strobe,
  output logic        hiGate,
  output logic        loGate
);

  gate_state_t state;
  gate_state_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_SAFE: begin
        nextState = pwmIn ? ST_HIGH : ST_LOW;
      end
      ST_LOW: begin
        if (pwmIn) begin
          nextState        = ST_RISE_GAP;
          strobe.start     = 1'b1;
          strobe.startRise = 1'b1;
        end
      end
      ST_RISE_GAP: begin
        if (!pwmIn) begin
          nextState = ST_LOW;            // glitch: restore lower switch
        end else if (gapDone) begin
          nextState     = ST_HIGH;
          strobe.commit = 1'b1;
        end else begin
          strobe.tick = 1'b1;
        end
      end
      ST_HIGH: begin
        if (!pwmIn) begin
          nextState    = ST_FALL_GAP;
          strobe.start = 1'b1;
        end
      end
      ST_FALL_GAP: begin
        if (pwmIn) begin
          nextState = ST_HIGH;           // glitch: restore upper switch
        end else if (gapDone) begin
          nextState     = ST_LOW;
          strobe.commit = 1'b1;
        end else begin
          strobe.tick = 1'b1;
        end
      end
      default: nextState = ST_SAFE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_SAFE;
    end else begin
      state <= nextState;
    end
  end

  assign hiGate = (state == ST_HIGH);
  assign loGate = (state == ST_LOW);

endmodule

// File: rtl/deadtime_gate_ctrl.sv
`timescale 1ns/1ps
module deadtime_gate_ctrl
  import dtg_pkg::*;
#(
  parameter int DT_MIN    = 1,
  parameter int DT_MAX    = 20,
  parameter int DT_INIT   = 4,
  parameter int ADAPT_DLY = 6,
  localparam int DLY_W    = $clog2(DT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwmIn,
  input  logic             phaseNeg,
  input  logic             sinkMode,
  output logic             hiGate,
  output logic             loGate,
  output logic [DLY_W-1:0] riseDelay,
  output logic [DLY_W-1:0] fallDelay
);

  gap_strobe_t gapStrobe;
  logic        gapDone;

  dtg_control ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pwmIn  (pwmIn),
    .gapDone(gapDone),
    .strobe (gapStrobe),
    .hiGate (hiGate),
    .loGate (loGate)
  );

  dtg_datapath #(
    .DT_MIN   (DT_MIN),
    .DT_MAX   (DT_MAX),
    .DT_INIT  (DT_INIT),
    .ADAPT_DLY(ADAPT_DLY)
  ) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .phaseNeg (phaseNeg),
    .sinkMode (sinkMode),
    .strobe   (gapStrobe),
    .gapDone  (gapDone),
    .riseDelay(riseDelay),
    .fallDelay(fallDelay)
  );

endmodule

// File: rtl/dtg_checker.sv
`timescale 1ns/1ps
module dtg_checker #(
  parameter int DT_MIN   = 1,
  parameter int DT_MAX   = 20,
  localparam int DLY_W   = $clog2(DT_MAX + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwmIn,
  input logic             hiGate,
  input logic             loGate,
  input logic [DLY_W-1:0] riseDelay,
  input logic [DLY_W-1:0] fallDelay
);

  localparam logic [DLY_W-1:0] MIN_V = DLY_W'(DT_MIN);
  localparam logic [DLY_W-1:0] MAX_V = DLY_W'(DT_MAX);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(hiGate && loGate)); // R1

  AST_LO_DROPS_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (loGate && pwmIn) |=> !loGate); // R3

  AST_HI_DROPS_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (hiGate && !pwmIn) |=> !hiGate); // R4

  AST_RISE_ONLY_ON_HI: assert property (@(posedge clk) disable iff (!rstN)
    (riseDelay != $past(riseDelay)) |-> $rose(hiGate)); // R7

  AST_FALL_ONLY_ON_LO: assert property (@(posedge clk) disable iff (!rstN)
    (fallDelay != $past(fallDelay)) |-> $rose(loGate)); // R7

  AST_HI_NEEDS_PWM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiGate) |-> $past(pwmIn)); // R9

  AST_DLY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (riseDelay >= MIN_V) && (riseDelay <= MAX_V) &&
    (fallDelay >= MIN_V) && (fallDelay <= MAX_V)); // R10

endmodule

bind deadtime_gate_ctrl dtg_checker #(
  .DT_MIN(DT_MIN),
  .DT_MAX(DT_MAX)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .pwmIn    (pwmIn),
  .hiGate   (hiGate),
  .loGate   (loGate),
  .riseDelay(riseDelay),
  .fallDelay(fallDelay)
);

// File: tb/deadtime_gate_ctrl_test.sv
`timescale 1ns/1ps
module deadtime_gate_ctrl_test;

  localparam int DT_MIN    = 1;
  localparam int DT_MAX    = 20;
  localparam int DT_INIT   = 4;
  localparam int ADAPT_DLY = 6;
  localparam int DLY_W     = $clog2(DT_MAX + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmIn = 1'b0;
  logic phaseNeg = 1'b0;
  logic sinkMode = 1'b0;
  logic hiGate, loGate;
  logic [DLY_W-1:0] riseDelay, fallDelay;

  int checks = 0;
  int errors = 0;
  int riseExp = DT_INIT;
  int fallExp = DT_INIT;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  deadtime_gate_ctrl #(
    .DT_MIN(DT_MIN), .DT_MAX(DT_MAX), .DT_INIT(DT_INIT), .ADAPT_DLY(ADAPT_DLY)
  ) uut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .phaseNeg(phaseNeg), .sinkMode(sinkMode),
    .hiGate(hiGate), .loGate(loGate), .riseDelay(riseDelay), .fallDelay(fallDelay)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int stepVal(input int v, input bit neg);
    if (neg) return (v > DT_MIN) ? v - 1 : DT_MIN;
    return (v < DT_MAX) ? v + 1 : DT_MAX;
  endfunction

  task automatic checkRange();
    check("R10 riseDelay in range", int'(riseDelay >= DT_MIN && riseDelay <= DT_MAX), 1);
    check("R10 fallDelay in range", int'(fallDelay >= DT_MIN && fallDelay <= DT_MAX), 1);
  endtask

  // lower gate on -> upper gate on
  task automatic riseEdge(input bit neg, input bit sink);
    int d;
    string tag;
    d = sink ? ADAPT_DLY : riseExp;
    @(negedge clk);
    pwmIn = 1'b1; phaseNeg = neg; sinkMode = sink;
    @(posedge clk); #1;
    check("R3 lo off after rise sampled", int'(loGate), 0);
    check("R1 no overlap", int'(hiGate & loGate), 0);
    for (int i = 1; i < d; i++) begin
      @(posedge clk); #1;
      check("R3 hi held off in gap", int'(hiGate), 0);
      check("R3 lo held off in gap", int'(loGate), 0);
    end
    @(posedge clk); #1;
    check("R3 hi on after gap", int'(hiGate), 1);
    check("R1 no overlap", int'(hiGate & loGate), 0);
    if (!sink) riseExp = stepVal(riseExp, neg);
    tag = sink ? "R8 rise value frozen" : (neg ? "R5 rise shortened" : "R6 rise lengthened");
    check(tag, int'(riseDelay), riseExp);
    check("R7 fall untouched by rise gap", int'(fallDelay), fallExp);
    checkRange();
    @(negedge clk);
    phaseNeg = 1'b0; sinkMode = 1'b0;
    @(negedge clk);
  endtask

  // upper gate on -> lower gate on
  task automatic fallEdge(input bit neg, input bit sink);
    int d;
    string tag;
    d = sink ? ADAPT_DLY : fallExp;
    @(negedge clk);
    pwmIn = 1'b0; phaseNeg = neg; sinkMode = sink;
    @(posedge clk); #1;
    check("R4 hi off after fall sampled", int'(hiGate), 0);
    check("R1 no overlap", int'(hiGate & loGate), 0);
    for (int i = 1; i < d; i++) begin
      @(posedge clk); #1;
      check("R4 lo held off in gap", int'(loGate), 0);
      check("R4 hi held off in gap", int'(hiGate), 0);
    end
    @(posedge clk); #1;
    check("R4 lo on after gap", int'(loGate), 1);
    check("R1 no overlap", int'(hiGate & loGate), 0);
    if (!sink) fallExp = stepVal(fallExp, neg);
    tag = sink ? "R8 fall value frozen" : (neg ? "R5 fall shortened" : "R6 fall lengthened");
    check(tag, int'(fallDelay), fallExp);
    check("R7 rise untouched by fall gap", int'(riseDelay), riseExp);
    checkRange();
    @(negedge clk);
    phaseNeg = 1'b0; sinkMode = 1'b0;
    @(negedge clk);
  endtask

  task automatic riseAbort();
    @(negedge clk);
    pwmIn = 1'b1; phaseNeg = 1'b1;
    @(posedge clk); #1;
    check("R9 lo off when gap opens", int'(loGate), 0);
    @(negedge clk);
    pwmIn = 1'b0;
    @(posedge clk); #1;
    check("R9 lo restored after glitch", int'(loGate), 1);
    check("R9 hi stays off after glitch", int'(hiGate), 0);
    check("R9 rise value kept", int'(riseDelay), riseExp);
    check("R9 fall value kept", int'(fallDelay), fallExp);
    @(negedge clk);
    phaseNeg = 1'b0;
  endtask

  task automatic fallAbort();
    @(negedge clk);
    pwmIn = 1'b0; phaseNeg = 1'b1;
    @(posedge clk); #1;
    check("R9 hi off when gap opens", int'(hiGate), 0);
    @(negedge clk);
    pwmIn = 1'b1;
    @(posedge clk); #1;
    check("R9 hi restored after glitch", int'(hiGate), 1);
    check("R9 lo stays off after glitch", int'(loGate), 0);
    check("R9 rise value kept", int'(riseDelay), riseExp);
    check("R9 fall value kept", int'(fallDelay), fallExp);
    @(negedge clk);
    phaseNeg = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1 (run completed)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 hi off in reset", int'(hiGate), 0);
    check("R2 lo off in reset", int'(loGate), 0);
    check("R2 rise init", int'(riseDelay), DT_INIT);
    check("R2 fall init", int'(fallDelay), DT_INIT);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R2 lo on after first edge", int'(loGate), 1);
    check("R2 hi off after first edge", int'(hiGate), 0);
    check("R2 rise unchanged", int'(riseDelay), DT_INIT);
    @(negedge clk);

    // rising gap climbs to the top clamp, falling gap sinks to the bottom clamp
    for (int k = 0; k < 18; k++) begin
      riseEdge(1'b0, 1'b0);
      fallEdge(1'b1, 1'b0);
    end
    check("R6 rise held at max", int'(riseDelay), DT_MAX);
    check("R5 fall held at min", int'(fallDelay), DT_MIN);

    // and back the other way, past both clamps
    for (int k = 0; k < 22; k++) begin
      riseEdge(1'b1, 1'b0);
      fallEdge(1'b0, 1'b0);
    end
    check("R5 rise held at min", int'(riseDelay), DT_MIN);
    check("R6 fall held at max", int'(fallDelay), DT_MAX);

    // all combinations of comparator and sinking flags on both edges
    for (int k = 0; k < 16; k++) begin
      riseEdge(k[0], k[1]);
      fallEdge(k[2], k[3]);
    end

    // glitches shorter than a gap
    riseAbort();
    riseEdge(1'b0, 1'b0);
    fallAbort();
    fallEdge(1'b1, 1'b0);
    riseAbort();

    // fallback gap from a minimum learned value
    for (int k = 0; k < 24; k++) begin
      riseEdge(1'b1, 1'b0);
      fallEdge(1'b1, 1'b0);
    end
    riseEdge(1'b0, 1'b1);
    fallEdge(1'b0, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule